// File: doc/BRIEF.md
# Interrupt Polarity Normalizer

This block sits between a set of peripheral interrupt sources and an upstream interrupt controller that accepts only active-high level requests. Each source line is brought into the clock domain through a two-flop synchronizer. It can then be inverted, and it is either passed through as a level or captured on a rising edge into a sticky pending bit. A per-line mask gates the result onto that line's output.

Software programs the block through a 16-bit register port with byte addresses. There are four banks: mask, polarity, acknowledge and mode. Line `n` maps to bit `n % 16` of word `n / 16`, and the words of a bank sit 4 bytes apart. The mask, polarity and mode banks read back their contents, so software can update them with read-modify-write. A write of ones to the acknowledge bank clears pending edge requests, unless the acknowledge function is removed by a parameter.

Top module: `irq_norm_ctrl`

## Requirements
- R1: After reset every implemented mask bit reads 1, every polarity and mode bit reads 0, no request is pending and every output is 0.
- R2: Line n is bit n%16 of word n/16. Bank bases are mask 0x00, polarity 0x10, acknowledge 0x20 and mode 0x30, and word w of a bank sits at base + 4*w. Mask, polarity and mode words read back what was written.
- R3: A mask bit of 1 forces that line's output to 0.
- R4: A polarity bit of 1 inverts the synchronized input, so a low input on a level-mode line drives its output high.
- R5: In level mode (mode bit 0) the output follows the normalized input. A change on the input appears at the output after the second rising clock edge, and not after the first.
- R6: In edge mode (mode bit 1) a rising normalized edge sets a pending bit. The output stays 1 after the input falls, until a 1 is written to that line's acknowledge bit.
- R7: Acknowledge bits written as 0 leave pending requests untouched, and the acknowledge bank always reads 0.
- R8: The mask acts after the pending latch. An edge taken while masked stays pending and drives the output once the line is unmasked.
- R9: When a new rising edge and an acknowledge of the same line land in the same cycle, the line stays pending.
- R10: With the acknowledge function disabled by parameter, writes to the acknowledge bank have no effect on pending requests.
- R11: Bits and words for lines at or above NUM_LINES read 0 and ignore writes. Addresses with bits [1:0] or [7:6] nonzero hit no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Raw asynchronous interrupt sources |
| reg_addr | input | 8 | Byte address of register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq_out | output | NUM_LINES | Active-high level requests toward parent |

## Verification
Two functions can meet in one cycle: a new rising edge that sets a pending bit, and an acknowledge write that clears the same bit. The bench first leaves a line pending. It then raises that input and times the acknowledge write so that it lands on the third clock edge after the input change, which is the edge on which the synchronized edge is detected. The test passes when the output is still high after that cycle. A separate acknowledge-only write must then clear the line, which shows that the earlier acknowledge was in fact overridden and not ignored.

// File: rtl/irqn_pkg.sv
package irqn_pkg;

    localparam int MAX_LINES = 64;
    localparam int REG_W     = 16;
    localparam int ADDR_W    = 8;

    typedef enum logic [1:0] {
        BK_MASK = 2'd0,
        BK_POL  = 2'd1,
        BK_ACK  = 2'd2,
        BK_MODE = 2'd3
    } bank_e;

    typedef struct packed {
        logic       hit;
        bank_e      bank;
        logic [1:0] word;
    } reg_sel_t;

    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_t r;
        r.hit  = (a[1:0] == 2'b00) && (a[7:6] == 2'b00);
        r.bank = bank_e'(a[5:4]);
        r.word = a[3:2];
        return r;
    endfunction

    function automatic int line_word(input int n);
        return n / REG_W;
    endfunction

    function automatic int line_bit(input int n);
        return n % REG_W;
    endfunction

endpackage

// File: rtl/irqn_sync.sv
module irqn_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/irqn_regfile.sv
module irqn_regfile
    import irqn_pkg::*;
#(
    parameter int NUM_LINES  = 64,
    parameter bit EOI_ENABLE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic [NUM_LINES-1:0] mask_q,
    output logic [NUM_LINES-1:0] pol_q,
    output logic [NUM_LINES-1:0] edge_q,
    output logic [NUM_LINES-1:0] eoi_clr
);
    reg_sel_t sel;
    logic     wr_hit;

    always_comb begin
        sel    = decode_addr(reg_addr);
        wr_hit = reg_wr && sel.hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            pol_q  <= '0;
            edge_q <= '0;
        end else if (wr_hit) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (line_word(i) == int'(sel.word)) begin
                    case (sel.bank)
                        BK_MASK: mask_q[i] <= reg_wdata[line_bit(i)];
                        BK_POL:  pol_q[i]  <= reg_wdata[line_bit(i)];
                        BK_MODE: edge_q[i] <= reg_wdata[line_bit(i)];
                        default: ;
                    endcase
                end
            end
        end
    end

    generate
        if (EOI_ENABLE) begin : g_ack
            always_comb begin
                eoi_clr = '0;
                if (wr_hit && sel.bank == BK_ACK) begin
                    for (int i = 0; i < NUM_LINES; i++) begin
                        if (line_word(i) == int'(sel.word))
                            eoi_clr[i] = reg_wdata[line_bit(i)];
                    end
                end
            end
        end else begin : g_no_ack
            assign eoi_clr = '0;
        end
    endgenerate

    always_comb begin
        reg_rdata = '0;
        if (sel.hit) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                if (line_word(i) == int'(sel.word)) begin
                    case (sel.bank)
                        BK_MASK: reg_rdata[line_bit(i)] = mask_q[i];
                        BK_POL:  reg_rdata[line_bit(i)] = pol_q[i];
                        BK_MODE: reg_rdata[line_bit(i)] = edge_q[i];
                        default: reg_rdata[line_bit(i)] = 1'b0;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/irqn_line_core.sv
module irqn_line_core #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] sync_q,
    input  logic [NUM_LINES-1:0] pol_q,
    input  logic [NUM_LINES-1:0] edge_q,
    input  logic [NUM_LINES-1:0] mask_q,
    input  logic [NUM_LINES-1:0] eoi_clr,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] irq_out
);
    generate
        for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_line
            logic norm;
            logic norm_d;
            logic rise;

            assign norm = sync_q[gi] ^ pol_q[gi];
            assign rise = norm && !norm_d;

            always_ff @(posedge clk) begin
                if (rst) begin
                    norm_d     <= 1'b0;
                    pend_q[gi] <= 1'b0;
                end else begin
                    norm_d <= norm;
                    if (!edge_q[gi])
                        pend_q[gi] <= 1'b0;
                    else if (rise)
                        pend_q[gi] <= 1'b1;
                    else if (eoi_clr[gi])
                        pend_q[gi] <= 1'b0;
                end
            end

            assign irq_out[gi] = (edge_q[gi] ? pend_q[gi] : norm) && !mask_q[gi];
        end
    endgenerate
endmodule

// File: rtl/irq_norm_ctrl.sv
module irq_norm_ctrl
    import irqn_pkg::*;
#(
    parameter int NUM_LINES  = 64,
    parameter bit EOI_ENABLE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    output logic [NUM_LINES-1:0] irq_out
);
    logic [NUM_LINES-1:0] sync_q;
    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] pol_q;
    logic [NUM_LINES-1:0] edge_q;
    logic [NUM_LINES-1:0] eoi_clr;
    logic [NUM_LINES-1:0] pend_q;

    irqn_sync #(.WIDTH(NUM_LINES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (irq_in),
        .q   (sync_q)
    );

    irqn_regfile #(.NUM_LINES(NUM_LINES), .EOI_ENABLE(EOI_ENABLE)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mask_q    (mask_q),
        .pol_q     (pol_q),
        .edge_q    (edge_q),
        .eoi_clr   (eoi_clr)
    );

    irqn_line_core #(.NUM_LINES(NUM_LINES)) core_i (
        .clk     (clk),
        .rst     (rst),
        .sync_q  (sync_q),
        .pol_q   (pol_q),
        .edge_q  (edge_q),
        .mask_q  (mask_q),
        .eoi_clr (eoi_clr),
        .pend_q  (pend_q),
        .irq_out (irq_out)
    );
endmodule

// File: rtl/irqn_checker.sv
module irqn_checker
    import irqn_pkg::*;
#(
    parameter int NUM_LINES  = 64,
    parameter bit EOI_ENABLE = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LINES-1:0] sync_q,
    input logic [NUM_LINES-1:0] pol_q,
    input logic [NUM_LINES-1:0] edge_q,
    input logic [NUM_LINES-1:0] mask_q,
    input logic [NUM_LINES-1:0] eoi_clr,
    input logic [NUM_LINES-1:0] pend_q,
    input logic [NUM_LINES-1:0] irq_out,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [REG_W-1:0]     reg_rdata
);
    logic [NUM_LINES-1:0] ref_norm;
    logic [NUM_LINES-1:0] ref_prev;

    assign ref_norm = sync_q ^ pol_q;

    always_ff @(posedge clk) begin
        if (rst) ref_prev <= '0;
        else     ref_prev <= ref_norm;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (irq_out == '0 && pend_q == '0));

    p_mask_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_out & mask_q) == '0);

    p_ack_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_addr[7:4] == 4'h2) |-> reg_rdata == '0);

    generate
        for (genvar gi = 0; gi < NUM_LINES; gi++) begin : g_chk
            p_level_follow_r5: assert property (@(posedge clk) disable iff (rst)
                !edge_q[gi] |-> irq_out[gi] == (ref_norm[gi] && !mask_q[gi]));

            p_pend_hold_r6: assert property (@(posedge clk) disable iff (rst)
                (pend_q[gi] && edge_q[gi] && !eoi_clr[gi]) |=> pend_q[gi]);

            p_edge_wins_r9: assert property (@(posedge clk) disable iff (rst)
                (edge_q[gi] && ref_norm[gi] && !ref_prev[gi]) |=> pend_q[gi]);

            if (!EOI_ENABLE) begin : g_inert
                p_ack_inert_r10: assert property (@(posedge clk) disable iff (rst)
                    (pend_q[gi] && edge_q[gi]) |=> pend_q[gi]);
            end
        end
    endgenerate
endmodule

bind irq_norm_ctrl irqn_checker #(
    .NUM_LINES  (NUM_LINES),
    .EOI_ENABLE (EOI_ENABLE)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .sync_q    (sync_q),
    .pol_q     (pol_q),
    .edge_q    (edge_q),
    .mask_q    (mask_q),
    .eoi_clr   (eoi_clr),
    .pend_q    (pend_q),
    .irq_out   (irq_out),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/irq_norm_ctrl_tb_top.sv
module irq_norm_ctrl_tb_top;

    localparam int LINES_A = 40;
    localparam int LINES_B = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic [LINES_A-1:0] irq_a = '0;
    logic [7:0]         addr_a = '0;
    logic               wr_a = 1'b0;
    logic [15:0]        wdata_a = '0;
    logic [15:0]        rdata_a;
    logic [LINES_A-1:0] out_a;

    logic [LINES_B-1:0] irq_b = '0;
    logic [7:0]         addr_b = '0;
    logic               wr_b = 1'b0;
    logic [15:0]        wdata_b = '0;
    logic [15:0]        rdata_b;
    logic [LINES_B-1:0] out_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_norm_ctrl #(.NUM_LINES(LINES_A), .EOI_ENABLE(1'b1)) dut_i (
        .clk(clk), .rst(rst), .irq_in(irq_a), .reg_addr(addr_a), .reg_wr(wr_a),
        .reg_wdata(wdata_a), .reg_rdata(rdata_a), .irq_out(out_a)
    );

    irq_norm_ctrl #(.NUM_LINES(LINES_B), .EOI_ENABLE(1'b0)) dut_noeoi_i (
        .clk(clk), .rst(rst), .irq_in(irq_b), .reg_addr(addr_b), .reg_wr(wr_b),
        .reg_wdata(wdata_b), .reg_rdata(rdata_b), .irq_out(out_b)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input bit on_b, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        if (on_b) begin addr_b = a; wdata_b = d; wr_b = 1'b1; end
        else      begin addr_a = a; wdata_a = d; wr_a = 1'b1; end
        @(negedge clk);
        wr_a = 1'b0;
        wr_b = 1'b0;
    endtask

    task automatic rd(input bit on_b, input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        if (on_b) begin addr_b = a; #1 d = rdata_b; end
        else      begin addr_a = a; #1 d = rdata_a; end
    endtask

    task automatic pulse_a(input int line);
        @(negedge clk); irq_a[line] = 1'b1;
        repeat (3) @(negedge clk);
        irq_a[line] = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check("R1 outputs", 64'(out_a), 64'h0);
        rd(0, 8'h00, v); check("R1 mask w0", 64'(v), 64'hFFFF);
        rd(0, 8'h04, v); check("R1 mask w1", 64'(v), 64'hFFFF);
        rd(0, 8'h08, v); check("R11 mask w2 partial", 64'(v), 64'h00FF);
        rd(0, 8'h0C, v); check("R11 mask w3 absent", 64'(v), 64'h0);
        rd(0, 8'h10, v); check("R1 pol w0", 64'(v), 64'h0);
        rd(0, 8'h34, v); check("R1 mode w1", 64'(v), 64'h0);
    endtask

    task automatic t_map();
        logic [15:0] v;
        wr(0, 8'h14, 16'hA5C3);
        rd(0, 8'h14, v); check("R2 pol w1 readback", 64'(v), 64'hA5C3);
        rd(0, 8'h10, v); check("R2 pol w0 untouched", 64'(v), 64'h0);
        wr(0, 8'h14, 16'h0000);
        wr(0, 8'h38, 16'hFFFF);
        rd(0, 8'h38, v); check("R11 mode w2 upper ignored", 64'(v), 64'h00FF);
        wr(0, 8'h38, 16'h0000);
        wr(0, 8'h0C, 16'h1234);
        rd(0, 8'h0C, v); check("R11 w3 write ignored", 64'(v), 64'h0);
        wr(0, 8'h01, 16'h0000);
        rd(0, 8'h00, v); check("R11 misaligned write ignored", 64'(v), 64'hFFFF);
        wr(0, 8'h40, 16'h0000);
        rd(0, 8'h00, v); check("R11 high address ignored", 64'(v), 64'hFFFF);
    endtask

    task automatic t_level();
        wr(0, 8'h00, 16'h0000);
        @(negedge clk); irq_a[3] = 1'b1;
        @(posedge clk); #2;
        check("R5 not after first edge", 64'(out_a[3]), 64'h0);
        @(posedge clk); #2;
        check("R5 after second edge", 64'(out_a[3]), 64'h1);
        @(negedge clk); irq_a[3] = 1'b0;
        repeat (3) @(negedge clk);
        check("R5 follows fall", 64'(out_a[3]), 64'h0);
        wr(0, 8'h10, 16'h0020);
        check("R4 inverted low input", 64'(out_a[5]), 64'h1);
        wr(0, 8'h00, 16'h0020);
        check("R3 mask forces zero", 64'(out_a[5]), 64'h0);
        wr(0, 8'h10, 16'h0000);
        wr(0, 8'h00, 16'hFFFF);
    endtask

    task automatic t_edge();
        logic [15:0] v;
        wr(0, 8'h34, 16'h0010);
        wr(0, 8'h04, 16'hFFEF);
        check("R6 idle before edge", 64'(out_a[20]), 64'h0);
        pulse_a(20);
        check("R6 latched after input fell", 64'(out_a[20]), 64'h1);
        wr(0, 8'h24, 16'hFFEF);
        check("R7 zero ack bit keeps pending", 64'(out_a[20]), 64'h1);
        rd(0, 8'h24, v); check("R7 ack bank reads zero", 64'(v), 64'h0);
        wr(0, 8'h24, 16'h0010);
        check("R6 ack clears", 64'(out_a[20]), 64'h0);
    endtask

    task automatic t_masked_pending();
        wr(0, 8'h34, 16'h0030);
        pulse_a(21);
        check("R8 masked edge hidden", 64'(out_a[21]), 64'h0);
        wr(0, 8'h04, 16'hFFCF);
        check("R8 shows after unmask", 64'(out_a[21]), 64'h1);
        wr(0, 8'h24, 16'h0020);
        check("R8 cleared by ack", 64'(out_a[21]), 64'h0);
    endtask

    task automatic t_collide();
        pulse_a(20);
        check("R9 setup pending", 64'(out_a[20]), 64'h1);
        @(negedge clk); irq_a[20] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        addr_a = 8'h24; wdata_a = 16'h0010; wr_a = 1'b1;
        @(negedge clk);
        wr_a = 1'b0;
        check("R9 edge wins over ack", 64'(out_a[20]), 64'h1);
        irq_a[20] = 1'b0;
        repeat (3) @(negedge clk);
        wr(0, 8'h24, 16'h0010);
        check("R9 later ack clears", 64'(out_a[20]), 64'h0);
    endtask

    task automatic t_noeoi();
        logic [15:0] v;
        wr(1, 8'h30, 16'h0001);
        wr(1, 8'h00, 16'hFFFE);
        @(negedge clk); irq_b[0] = 1'b1;
        repeat (3) @(negedge clk);
        irq_b[0] = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 edge latched", 64'(out_b[0]), 64'h1);
        wr(1, 8'h20, 16'h0001);
        repeat (2) @(negedge clk);
        check("R10 ack write inert", 64'(out_b[0]), 64'h1);
        rd(1, 8'h20, v); check("R10 ack bank reads zero", 64'(v), 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_map();
        t_level();
        t_edge();
        t_masked_pending();
        t_collide();
        t_noeoi();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule